// File: doc/BRIEF.md
# Serial Peripheral Interrupt Aggregator

This block gathers the interrupt sources of a serial port into one level-sensitive request line. It holds three registers behind a small 32-bit register port: a master gate, a cause register and a per-cause mask. One-cycle event pulses from the transfer logic latch cause bits. Two level inputs that describe the receive queue are merged into the cause register on every clock, so those causes cannot be lost while the condition lasts.

Software clears a cause by writing a 1 to its position in the cause register. That write flips the bit, so it also sets a bit that is already 0. The request line is the registered result of "master gate set and any unmasked cause pending". It therefore changes exactly one clock after the registers it depends on, and it has no combinational glitches.

Top module: `irq_agg_unit`

## Requirements
- R1: After reset the master gate, cause and mask registers all read 0, and `irq` is low.
- R2: The master gate lives at byte offset 0x1C. Only bit 31 is stored; all other bits read back 0.
- R3: A write to the cause register at offset 0x20 XORs the written word into the current value, so a 1 flips that bit and a 0 leaves it alone.
- R4: A one-cycle pulse sets a cause bit that stays set until it is toggled. The pulses and their bits are: receive overrun at bit 5, transmit half-empty at bit 6, transmit underrun at bit 3 and transmit empty at bit 2.
- R5: On every clock while `rx_has_data` is high, cause bit 8 is forced to 1. On every clock while `rx_is_full` is high, cause bit 4 is forced to 1. A toggle cannot clear either bit while its level is present.
- R6: When a pulse or level sets a bit in the same cycle that a toggle write flips it, the bit ends up 1.
- R7: The mask register at offset 0x28 stores and reads back all 32 bits.
- R8: `irq` goes high one clock after bit 31 of the master gate is set and (cause AND mask) is nonzero. It goes low one clock after either condition stops holding.
- R9: Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| ev_rx_overrun | input | 1 | Pulse: receive overrun |
| ev_tx_half_empty | input | 1 | Pulse: transmit queue half empty |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_tx_empty | input | 1 | Pulse: transmit queue empty |
| rx_has_data | input | 1 | Level: receive queue holds data |
| rx_is_full | input | 1 | Level: receive queue is full |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench checks toggle semantics in both directions:
- A design that cleared bits on write, instead of flipping them, would leave a 0 where writing a 1 to a clear bit must set it.
- A design that applied the toggle after the merge would drop a cause that is raised in the same cycle as its clear.

The bench holds each receive level high across a clearing write. A design that sampled the level only once would let the bit fall.

The bench also watches the request line on the cycle directly after the master gate and the mask change. A combinational output, or a design that ignored the gate or the mask, would show up as an early, missing or stuck request.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  localparam logic [7:0] OFS_GATE  = 8'h1C;
  localparam logic [7:0] OFS_CAUSE = 8'h20;
  localparam logic [7:0] OFS_MASK  = 8'h28;

  localparam int GATE_BIT     = REG_W - 1;
  localparam int BIT_RX_DATA  = 8;
  localparam int BIT_TX_HALF  = 6;
  localparam int BIT_RX_OVR   = 5;
  localparam int BIT_RX_FULL  = 4;
  localparam int BIT_TX_UDR   = 3;
  localparam int BIT_TX_EMPTY = 2;

  // Collect pulses and live levels into one set vector
  function automatic logic [REG_W-1:0] build_set_vec(
      input logic ovr, input logic half, input logic udr,
      input logic empty, input logic has_data, input logic full);
    logic [REG_W-1:0] v;
    v = '0;
    v[BIT_RX_OVR]   = ovr;
    v[BIT_TX_HALF]  = half;
    v[BIT_TX_UDR]   = udr;
    v[BIT_TX_EMPTY] = empty;
    v[BIT_RX_DATA]  = has_data;
    v[BIT_RX_FULL]  = full;
    return v;
  endfunction

  // Toggle first, then set: a set in the same cycle wins
  function automatic logic [REG_W-1:0] next_cause(
      input logic [REG_W-1:0] cur, input logic [REG_W-1:0] flip,
      input logic [REG_W-1:0] set_v);
    return (cur ^ flip) | set_v;
  endfunction

  function automatic logic want_irq(
      input logic gate, input logic [REG_W-1:0] cause,
      input logic [REG_W-1:0] mask);
    return gate & (|(cause & mask));
  endfunction
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
  import irq_agg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic          gate_q,
  input  logic [DW-1:0] cause_q,
  input  logic [DW-1:0] mask_q,
  output logic          wr_gate,
  output logic          wr_cause,
  output logic          wr_mask,
  output logic [DW-1:0] rdata
);
  logic hit_gate, hit_cause, hit_mask;

  assign hit_gate  = (addr == AW'(OFS_GATE));
  assign hit_cause = (addr == AW'(OFS_CAUSE));
  assign hit_mask  = (addr == AW'(OFS_MASK));

  assign wr_gate  = wr & hit_gate;
  assign wr_cause = wr & hit_cause;
  assign wr_mask  = wr & hit_mask;

  always_comb begin
    rdata = '0;
    if (hit_gate)  rdata[DW-1] = gate_q;
    if (hit_cause) rdata = cause_q;
    if (hit_mask)  rdata = mask_q;
  end
endmodule

// File: rtl/irq_agg_cause.sv
module irq_agg_cause
  import irq_agg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_cause,
  input  logic [DW-1:0] wdata,
  input  logic          ev_ovr,
  input  logic          ev_half,
  input  logic          ev_udr,
  input  logic          ev_empty,
  input  logic          lv_has_data,
  input  logic          lv_full,
  output logic [DW-1:0] cause_q
);
  logic [DW-1:0] set_vec;
  logic [DW-1:0] flip_vec;

  assign set_vec  = build_set_vec(ev_ovr, ev_half, ev_udr, ev_empty,
                                  lv_has_data, lv_full);
  assign flip_vec = wr_cause ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= next_cause(cause_q, flip_vec, set_vec);
  end

  // R3: bit 0 has no set source, so it follows the toggle alone
  a_r3_toggle_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cause |=> cause_q[0] == ($past(cause_q[0]) ^ $past(wdata[0])));
  a_r3_hold_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_cause |=> $stable(cause_q[0]));
  a_r4_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ovr |=> cause_q[BIT_RX_OVR]);
  a_r5_live_data: assert property (@(posedge clk) disable iff (!rst_n)
    lv_has_data |=> cause_q[BIT_RX_DATA]);
  a_r5_live_full: assert property (@(posedge clk) disable iff (!rst_n)
    lv_full |=> cause_q[BIT_RX_FULL]);
  a_r6_set_beats_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_udr && wr_cause && wdata[BIT_TX_UDR]) |=> cause_q[BIT_TX_UDR]);
endmodule

// File: rtl/irq_agg_enables.sv
module irq_agg_enables
  import irq_agg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_gate,
  input  logic          wr_mask,
  input  logic [DW-1:0] wdata,
  output logic          gate_q,
  output logic [DW-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      mask_q <= '0;
    end else begin
      if (wr_gate) gate_q <= wdata[DW-1];
      if (wr_mask) mask_q <= wdata;
    end
  end

  a_r2_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_gate |=> $stable(gate_q));
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));
endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out
  import irq_agg_pkg::*;
#(
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          gate_q,
  input  logic [DW-1:0] cause_q,
  input  logic [DW-1:0] mask_q,
  output logic          irq_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= want_irq(gate_q, cause_q, mask_q);
  end

  a_r8_irq_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_q && ((cause_q & mask_q) != '0)) |=> irq_q);
  a_r8_irq_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_q || ((cause_q & mask_q) == '0)) |=> !irq_q);
endmodule

// File: rtl/irq_agg_unit.sv
module irq_agg_unit
  import irq_agg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ev_rx_overrun,
  input  logic          ev_tx_half_empty,
  input  logic          ev_tx_underrun,
  input  logic          ev_tx_empty,
  input  logic          rx_has_data,
  input  logic          rx_is_full,
  output logic          irq
);
  logic          wr_gate, wr_cause, wr_mask;
  logic          gate_q;
  logic [DW-1:0] cause_q, mask_q;

  irq_agg_decode #(.AW(AW), .DW(DW)) u_decode (
    .wr(bus_wr), .addr(bus_addr), .gate_q(gate_q), .cause_q(cause_q),
    .mask_q(mask_q), .wr_gate(wr_gate), .wr_cause(wr_cause),
    .wr_mask(wr_mask), .rdata(bus_rdata));

  irq_agg_cause #(.DW(DW)) u_cause (
    .clk(clk), .rst_n(rst_n), .wr_cause(wr_cause), .wdata(bus_wdata),
    .ev_ovr(ev_rx_overrun), .ev_half(ev_tx_half_empty),
    .ev_udr(ev_tx_underrun), .ev_empty(ev_tx_empty),
    .lv_has_data(rx_has_data), .lv_full(rx_is_full), .cause_q(cause_q));

  irq_agg_enables #(.DW(DW)) u_enables (
    .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate), .wr_mask(wr_mask),
    .wdata(bus_wdata), .gate_q(gate_q), .mask_q(mask_q));

  irq_agg_out #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .gate_q(gate_q), .cause_q(cause_q),
    .mask_q(mask_q), .irq_q(irq));
endmodule

// File: tb/irq_agg_unit_bench.sv
module irq_agg_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic ev_ovr = 0, ev_half = 0, ev_udr = 0, ev_empty = 0;
  logic rx_has_data = 0, rx_is_full = 0;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg_unit u_irq_agg_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_overrun(ev_ovr), .ev_tx_half_empty(ev_half),
    .ev_tx_underrun(ev_udr), .ev_tx_empty(ev_empty),
    .rx_has_data(rx_has_data), .rx_is_full(rx_is_full), .irq(irq));

  task automatic check(input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic [3:0] sel);
    @(negedge clk);
    {ev_ovr, ev_half, ev_udr, ev_empty} = sel;
    @(negedge clk);
    {ev_ovr, ev_half, ev_udr, ev_empty} = 4'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h1C, v); check("R1 gate", v, 0);
    rd(8'h20, v); check("R1 cause", v, 0);
    rd(8'h28, v); check("R1 mask", v, 0);
    check("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, v); check("R2 gate bit31 only", v, 32'h8000_0000);
    wr(8'h1C, 32'h7FFF_FFFF);
    rd(8'h1C, v); check("R2 gate clear", v, 0);
    wr(8'h28, 32'hA5A5_0F0F);
    rd(8'h28, v); check("R7 mask readback", v, 32'hA5A5_0F0F);
    wr(8'h28, 32'h0);
    wr(8'h24, 32'hFFFF_FFFF);
    rd(8'h24, v); check("R9 unmapped read", v, 0);
    rd(8'h20, v); check("R9 cause untouched", v, 0);
    rd(8'h28, v); check("R9 mask untouched", v, 0);
    rd(8'h1C, v); check("R9 gate untouched", v, 0);
  endtask

  task automatic t_toggle();
    logic [31:0] v;
    wr(8'h20, 32'h0000_0121);
    rd(8'h20, v); check("R3 toggle sets", v, 32'h0000_0121);
    wr(8'h20, 32'h0000_0021);
    rd(8'h20, v); check("R3 toggle clears", v, 32'h0000_0100);
    wr(8'h20, 32'h0000_0100);
    rd(8'h20, v); check("R3 back to zero", v, 0);
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(4'b1000);
    rd(8'h20, v); check("R4 overrun bit5", v, 32'h0000_0020);
    repeat (3) @(negedge clk);
    rd(8'h20, v); check("R4 overrun held", v, 32'h0000_0020);
    pulse(4'b0111);
    rd(8'h20, v); check("R4 half/udr/empty bits 6,3,2", v, 32'h0000_006C);
    wr(8'h20, 32'h0000_006C);
    rd(8'h20, v); check("R4 cleared", v, 0);
  endtask

  task automatic t_live();
    logic [31:0] v;
    @(negedge clk); rx_has_data = 1'b1;
    @(negedge clk);
    rd(8'h20, v); check("R5 live data bit8", v, 32'h0000_0100);
    wr(8'h20, 32'h0000_0100);
    rd(8'h20, v); check("R5 clear blocked bit8", v, 32'h0000_0100);
    rx_has_data = 1'b0; rx_is_full = 1'b1;
    @(negedge clk);
    rx_is_full = 1'b0;
    wr(8'h20, 32'h0000_0100);
    rd(8'h20, v); check("R5 full bit4 latched", v, 32'h0000_0010);
    wr(8'h20, 32'h0000_0010);
    rd(8'h20, v); check("R5 cleared after level drop", v, 0);
  endtask

  task automatic t_priority();
    logic [31:0] v;
    pulse(4'b0010);
    rd(8'h20, v); check("R6 setup bit3", v, 32'h0000_0008);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h0000_0009; ev_udr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0; ev_udr = 1'b0;
    rd(8'h20, v); check("R6 set wins over toggle", v, 32'h0000_0009);
  endtask

  task automatic t_irq();
    // cause = 0x9 here
    wr(8'h28, 32'h0000_0004);
    wr(8'h1C, 32'h8000_0000);
    @(negedge clk);
    check("R8 masked cause no irq", {31'b0, irq}, 0);
    wr(8'h28, 32'h0000_0008);
    check("R8 one-cycle lag", {31'b0, irq}, 0);
    @(negedge clk);
    check("R8 irq raised", {31'b0, irq}, 1);
    wr(8'h1C, 32'h0);
    check("R8 still high one cycle", {31'b0, irq}, 1);
    @(negedge clk);
    check("R8 gate off drops irq", {31'b0, irq}, 0);
    wr(8'h1C, 32'h8000_0000);
    wr(8'h20, 32'h0000_0009);
    @(negedge clk);
    check("R8 cause cleared drops irq", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_map();
    t_toggle();
    t_events();
    t_live();
    t_priority();
    t_irq();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule